// File: doc/BRIEF.md
# Replicated Multi-Read-Port Shared Memory

This block is a shared word memory for a small multicore processor. Every core gets its own read port. All ports can read different addresses in the same clock cycle, so instruction and data fetches are never serialised through one port. The memory keeps one identical copy of the storage array for each read port. Each read port reads only from its own copy.

Several requesters may want to write at the same time. A fixed-priority selector commits exactly one of their writes per cycle, and requester 0 has the highest priority. The committed word is written into every copy on the same clock edge, so all copies always hold the same contents. A requester that loses sees its grant held low and keeps its request up until it wins.

On reset every copy is loaded with a computed pattern: word `a` holds `INIT_SEED ^ a`. Reads are synchronous and registered.

Top module: `rmem_top`

## Requirements
- R1: While reset is asserted, and after release before any read enable, every `rd_valid` bit is 0 and every `rd_data` lane is 0. With no write requests, `wr_gnt` is 0.
- R2: After reset, and before any write, a read of address `a` returns `INIT_SEED ^ a`, with `a` zero-extended to the data width.
- R3: Each read port is independent. In one cycle, each port may present its own address, and each returns the word at that address on its own `rd_data` lane in the next cycle. Lane `p` is bits `[p*DATA_W +: DATA_W]` and its address is `rd_addr[p*ADDR_W +: ADDR_W]`.
- R4: `rd_valid[p]` is 1 in exactly the cycle after a cycle with `rd_en[p]` high, and 0 otherwise.
- R5: When `rd_en[p]` is low, lane `p` of `rd_data` keeps its previous value.
- R6: `wr_gnt` is combinational from `wr_req`. It has exactly one bit set, at the lowest-numbered requesting index, when any request is high, and it is all zero otherwise.
- R7: The write of the granted requester takes effect at the clock edge. Every read port sees it on any later read of that address.
- R8: Data and addresses from requesters that are not granted never reach the memory.
- R9: A read issued in the same cycle as a write to the same address returns the value from before the write, on every port.
- R10: With `wr_req` all zero, the values on `wr_addr` and `wr_data` do not change the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | WR_REQS | Write request per requester |
| wr_addr | input | WR_REQS*ADDR_W | Write address per requester, packed by index |
| wr_data | input | WR_REQS*DATA_W | Write data per requester, packed by index |
| wr_gnt | output | WR_REQS | One-hot grant, requester 0 highest priority |
| rd_en | input | RD_PORTS | Read enable per port |
| rd_addr | input | RD_PORTS*ADDR_W | Read address per port, packed by index |
| rd_data | output | RD_PORTS*DATA_W | Registered read data per port |
| rd_valid | output | RD_PORTS | Read data valid, one cycle after enable |

## Verification
The bench reads the whole reset image through all ports at once, with staggered addresses. This exposes any copy that differs from the others or any lane that is wired to the wrong copy. It drives every request pattern of the small requester set, so both the priority order and the rule that losers do not write are tested. A full readback against an arithmetic model then shows any stray write. Dedicated cycles cover a same-address read during a write, read enables in a sparse pattern that check that idle lanes hold their data, and cycles with garbage write inputs but no request.

// File: rtl/rmem_pkg.sv
package rmem_pkg;

    // Widest requester set the selector helper supports.
    localparam int unsigned RMEM_SEL_MAX = 64;

    // Keep only the least significant set bit of a request vector.
    function automatic logic [RMEM_SEL_MAX-1:0] keep_lowest(input logic [RMEM_SEL_MAX-1:0] v);
        return v & (~v + RMEM_SEL_MAX'(1));
    endfunction

endpackage

// File: rtl/rmem_prio_arb.sv
module rmem_prio_arb #(
    parameter int N = 8
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    logic [rmem_pkg::RMEM_SEL_MAX-1:0] wide_d;

    always_comb begin
        wide_d = rmem_pkg::keep_lowest(rmem_pkg::RMEM_SEL_MAX'(req));
        gnt    = wide_d[N-1:0];
    end
endmodule

// File: rtl/rmem_bank.sv
module rmem_bank #(
    parameter int              DATA_W    = 32,
    parameter int              DEPTH     = 256,
    parameter int              ADDR_W    = 8,
    parameter logic [DATA_W-1:0] INIT_SEED = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
    } rport_t;

    logic [DATA_W-1:0] mem_q [DEPTH];
    rport_t            rp_d, rp_q;

    // Read side: sample the array before this edge's write lands.
    always_comb begin
        rp_d       = rp_q;
        rp_d.valid = re;
        if (re) begin
            rp_d.data = mem_q[raddr];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rp_q <= '0;
        end else begin
            rp_q <= rp_d;
        end
    end

    // Storage copy: reset image is seed xor address.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) begin
                mem_q[a] <= INIT_SEED ^ DATA_W'(a);
            end
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata  = rp_q.data;
    assign rvalid = rp_q.valid;
endmodule

// File: rtl/rmem_top.sv
module rmem_top #(
    parameter int                DATA_W    = 32,
    parameter int                DEPTH     = 256,
    parameter int                RD_PORTS  = 8,
    parameter int                WR_REQS   = 8,
    parameter logic [DATA_W-1:0] INIT_SEED = DATA_W'(32'h5A3C_0000),
    localparam int               ADDR_W    = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [WR_REQS-1:0]           wr_req,
    input  logic [WR_REQS*ADDR_W-1:0]    wr_addr,
    input  logic [WR_REQS*DATA_W-1:0]    wr_data,
    output logic [WR_REQS-1:0]           wr_gnt,
    input  logic [RD_PORTS-1:0]          rd_en,
    input  logic [RD_PORTS*ADDR_W-1:0]   rd_addr,
    output logic [RD_PORTS*DATA_W-1:0]   rd_data,
    output logic [RD_PORTS-1:0]          rd_valid
);
    logic              commit_we;
    logic [ADDR_W-1:0] commit_addr;
    logic [DATA_W-1:0] commit_data;

    rmem_prio_arb #(.N(WR_REQS)) u_arb (
        .req (wr_req),
        .gnt (wr_gnt)
    );

    // One-hot grant steers the winning address and data.
    always_comb begin
        commit_we   = |wr_gnt;
        commit_addr = '0;
        commit_data = '0;
        for (int i = 0; i < WR_REQS; i++) begin
            if (wr_gnt[i]) begin
                commit_addr = commit_addr | wr_addr[i*ADDR_W +: ADDR_W];
                commit_data = commit_data | wr_data[i*DATA_W +: DATA_W];
            end
        end
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_copy
        rmem_bank #(
            .DATA_W    (DATA_W),
            .DEPTH     (DEPTH),
            .ADDR_W    (ADDR_W),
            .INIT_SEED (INIT_SEED)
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     (commit_we),
            .waddr  (commit_addr),
            .wdata  (commit_data),
            .re     (rd_en[p]),
            .raddr  (rd_addr[p*ADDR_W +: ADDR_W]),
            .rdata  (rd_data[p*DATA_W +: DATA_W]),
            .rvalid (rd_valid[p])
        );
    end
endmodule

// File: rtl/rmem_checker.sv
module rmem_checker #(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8,
    parameter int RD_PORTS = 8,
    parameter int WR_REQS  = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [WR_REQS-1:0]         wr_req,
    input logic [WR_REQS-1:0]         wr_gnt,
    input logic [RD_PORTS-1:0]        rd_en,
    input logic [RD_PORTS*ADDR_W-1:0] rd_addr,
    input logic [RD_PORTS*DATA_W-1:0] rd_data,
    input logic [RD_PORTS-1:0]        rd_valid
);
    // R6: at most one grant, only to a requester, and someone wins if anyone asks
    a_r6_gnt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_gnt));
    a_r6_gnt_subset: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_gnt & ~wr_req) == '0);
    a_r6_gnt_any: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_req) |-> (|wr_gnt));

    // R4: valid follows enable by one cycle
    a_r4_valid_lag: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (rd_valid == $past(rd_en)));

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_port
        // R5: idle lane holds its data
        a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_en[p] |=> $stable(rd_data[p*DATA_W +: DATA_W]));
    end

    for (genvar j = 1; j < RD_PORTS; j++) begin : g_pair
        // R3: copies agree when two ports read the same address
        a_r3_copies_agree: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en[0] && rd_en[j] && (rd_addr[0 +: ADDR_W] == rd_addr[j*ADDR_W +: ADDR_W]))
            |=> (rd_data[0 +: DATA_W] == rd_data[j*DATA_W +: DATA_W]));
    end
endmodule

bind rmem_top rmem_checker #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .RD_PORTS (RD_PORTS),
    .WR_REQS  (WR_REQS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_req   (wr_req),
    .wr_gnt   (wr_gnt),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
);

// File: tb/tb_rmem_top.sv
module tb_rmem_top;
    localparam int                DW   = 32;
    localparam int                DEP  = 32;
    localparam int                AW   = 5;
    localparam int                NRD  = 8;
    localparam int                NWR  = 4;
    localparam logic [DW-1:0]     SEED = 32'hA5C3_0F00;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NWR-1:0]      wr_req = '0;
    logic [NWR*AW-1:0]   wr_addr = '0;
    logic [NWR*DW-1:0]   wr_data = '0;
    logic [NWR-1:0]      wr_gnt;
    logic [NRD-1:0]      rd_en = '0;
    logic [NRD*AW-1:0]   rd_addr = '0;
    logic [NRD*DW-1:0]   rd_data;
    logic [NRD-1:0]      rd_valid;

    rmem_top #(
        .DATA_W(DW), .DEPTH(DEP), .RD_PORTS(NRD), .WR_REQS(NWR), .INIT_SEED(SEED)
    ) dut (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_gnt(wr_gnt), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    always #10 clk = ~clk;

    int total = 0;
    int bad   = 0;

    logic [DW-1:0] model   [DEP];
    logic [DW-1:0] last_rd [NRD];
    logic [AW-1:0] ra [NRD];
    logic [AW-1:0] wa [NWR];
    logic [DW-1:0] wd [NWR];
    logic [NRD-1:0] en_v;
    logic [NWR-1:0] req_v;

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive at a falling edge, check grant, check reads at next falling edge.
    task automatic step(input string tag);
        logic [DW-1:0] exp_rd [NRD];
        logic [NWR-1:0] exp_g;
        int win;
        for (int p = 0; p < NRD; p++) begin
            rd_addr[p*AW +: AW] = ra[p];
            exp_rd[p] = en_v[p] ? model[ra[p]] : last_rd[p];
        end
        for (int w = 0; w < NWR; w++) begin
            wr_addr[w*AW +: AW] = wa[w];
            wr_data[w*DW +: DW] = wd[w];
        end
        rd_en  = en_v;
        wr_req = req_v;
        win = -1;
        for (int w = NWR - 1; w >= 0; w--) if (req_v[w]) win = w;
        exp_g = '0;
        if (win >= 0) exp_g[win] = 1'b1;
        #1;
        chk(wr_gnt == exp_g, "R6 grant", DW'(wr_gnt), DW'(exp_g));
        @(negedge clk);
        for (int p = 0; p < NRD; p++) begin
            chk(rd_valid[p] == en_v[p], "R4 valid", DW'(rd_valid[p]), DW'(en_v[p]));
            chk(rd_data[p*DW +: DW] == exp_rd[p], tag, rd_data[p*DW +: DW], exp_rd[p]);
            last_rd[p] = exp_rd[p];
        end
        if (win >= 0) model[wa[win]] = wd[win];
    endtask

    task automatic readback(input string tag);
        req_v = '0;
        en_v  = '1;
        for (int base = 0; base < DEP; base++) begin
            for (int p = 0; p < NRD; p++) ra[p] = AW'((base + p * 5) % DEP);
            step(tag);
        end
    endtask

    initial begin
        for (int a = 0; a < DEP; a++) model[a] = SEED ^ DW'(a);
        for (int p = 0; p < NRD; p++) begin last_rd[p] = '0; ra[p] = '0; end
        for (int w = 0; w < NWR; w++) begin wa[w] = '0; wd[w] = '0; end
        en_v = '0; req_v = '0;

        // R1: state during reset
        #40;
        chk(rd_valid == '0, "R1 valid in reset", DW'(rd_valid), '0);
        chk(rd_data == '0, "R1 data in reset", rd_data[DW-1:0], '0);
        chk(wr_gnt == '0, "R1 grant idle", DW'(wr_gnt), '0);
        #15 rst_n = 1'b1;
        @(negedge clk);
        chk(rd_valid == '0, "R1 valid after release", DW'(rd_valid), '0);
        chk(rd_data == '0, "R1 data after release", rd_data[DW-1:0], '0);

        // R2 R3: reset image on all ports with staggered addresses
        readback("R2 R3 init image");

        // R6 R8: every request pattern, losers carry distinct data
        en_v = '0;
        for (int pat = 0; pat < (1 << NWR); pat++) begin
            req_v = NWR'(pat);
            for (int w = 0; w < NWR; w++) begin
                wa[w] = AW'((pat * 3 + w * 7) % DEP);
                wd[w] = 32'h1000_0000 * (w + 1) + DW'(pat * 16 + w);
            end
            step("R6 pattern");
        end
        readback("R7 R8 after contention");

        // R10: garbage on write inputs with no request
        req_v = '0; en_v = '0;
        for (int k = 0; k < 4; k++) begin
            for (int w = 0; w < NWR; w++) begin
                wa[w] = AW'(k * 4 + w);
                wd[w] = 32'hDEAD_0000 + DW'(k * 8 + w);
            end
            step("R10 no request");
        end
        readback("R10 unchanged");

        // R9: same-address read during write returns old data everywhere
        for (int w = 0; w < NWR; w++) begin wa[w] = AW'(9); wd[w] = 32'hBEEF_0000 + DW'(w); end
        req_v = 4'b0100;
        en_v  = '1;
        for (int p = 0; p < NRD; p++) ra[p] = AW'(9);
        step("R9 read before write");
        req_v = '0;
        step("R7 new value visible");

        // R5: idle lanes hold, sparse enables
        en_v = '0;
        step("R5 all idle");
        en_v = 8'b1010_0101;
        for (int p = 0; p < NRD; p++) ra[p] = AW'(p * 3 + 1);
        step("R3 R5 sparse");
        en_v = 8'b0101_1010;
        for (int p = 0; p < NRD; p++) ra[p] = AW'(30 - p);
        step("R3 R5 sparse swap");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule